// File: doc/BRIEF.md
# Retirement Result Checker

This block guards the architected integer register file of a speculative processor core. In each cycle the core offers a retirement group of up to four instructions. Each instruction carries an opcode, source and destination register indices, an optional immediate and its program counter, plus the result the core claims to have computed. The checker keeps the architected register file itself. It reads fresh operands from that file and forwards values between the slots of a group in program order. A small integer ALU recomputes every valid result, and a value is committed only after it agrees with the recomputation.

When the recomputation and the core disagree, the checker does not act on the first comparison. It holds the core for one cycle by dropping `retire_ready` and evaluates the group a second time. If the disagreement is still there, it commits the slots before the faulty one, writes its own value for the faulty slot and drops the rest of the group. It then pulses a restart request that carries the address after the faulty instruction. If the second evaluation agrees with the core, the whole group commits as if nothing had happened, which filters out a transient upset inside the checker.

Top module: `retire_checker`

## Requirements
- R1: A result reaches the architected register file, and the commit ports, only in a cycle where `retire_ready` is high. It is written at the rising edge that ends that cycle, and `commit_data` always holds the checker's recomputed value.
- R2: If every valid slot matches its recomputation, the group is accepted in the same cycle. Each valid slot with a nonzero destination commits the core's value unchanged, and no restart is raised.
- R3: On any mismatch, the first evaluation holds `retire_ready` low with no commit. The following cycle raises `retire_ready` again, so a mismatch costs exactly one extra cycle.
- R4: If slot k is the lowest-numbered mismatching valid slot on the second evaluation, then valid slots 0..k commit, with slot k carrying the recomputed value. Slots above k are dropped. `restart_req` pulses in that cycle with `restart_pc` = PC of slot k + 4.
- R5: Slots are checked in program order, slot 0 first. A source register written by an earlier valid slot of the same group reads that slot's recomputed value, and the latest such writer wins. If two slots write the same register, the later one is what remains in the file.
- R6: Opcode encoding on a 4-bit field: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 SLL, 6 SRL (logical), 7 SLT (signed compare, result 1 or 0). Shifts use only the low 5 bits of the second operand. All operands are 32 bits.
- R7: When a slot's `retire_use_imm` bit is set, the second operand is that slot's immediate instead of the second source register.
- R8: Opcodes 8 to 15 always count as a mismatch. The checker's value for such a slot is zero.
- R9: Register 0 reads as zero, also within a group after an earlier slot names it as destination. A slot whose destination is register 0 never asserts its commit strobe.
- R10: A slot whose valid bit is low is neither checked nor committed, never causes a stall or restart, and never forwards its value.
- R11: After reset every architected register holds zero, `retire_ready` is high, and no commit or restart is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 4 | Per-slot valid bits of the retiring group |
| retire_op | input | 4x4 | Per-slot opcode |
| retire_rs1 | input | 4x5 | Per-slot first source register |
| retire_rs2 | input | 4x5 | Per-slot second source register |
| retire_rd | input | 4x5 | Per-slot destination register |
| retire_use_imm | input | 4 | Per-slot select of immediate as second operand |
| retire_imm | input | 4x32 | Per-slot immediate |
| retire_result | input | 4x32 | Result computed by the core |
| retire_pc | input | 4x32 | Per-slot instruction address |
| retire_ready | output | 1 | Group accepted this cycle; low means hold the group |
| commit_valid | output | 4 | Per-slot commit strobe |
| commit_rd | output | 4x5 | Per-slot committed destination |
| commit_data | output | 4x32 | Per-slot committed (verified or corrected) value |
| restart_req | output | 1 | Pulse requesting the core to flush and restart |
| restart_pc | output | 32 | Address to restart from |

## Verification
The assertions check on every cycle that a stall lasts one cycle and never carries a commit. They also check that a restart only follows a stall, and that a commit strobe never appears on an invalid slot. Correct arithmetic for each opcode, forwarding between slots and the rule that the latest writer wins can only be shown by the bench's scenarios. The same goes for the choice of the first faulty slot, the dropping of later slots, the corrected value and the restart address. The bench shows the resulting register state by reading it back through later groups, which would mismatch if the state were wrong.

// File: rtl/retire_checker_pkg.sv
package retire_checker_pkg;

    localparam int XLEN = 32;
    localparam int OPW  = 4;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SLT = 4'd7
    } op_e;

    typedef struct packed {
        logic            known;
        logic [XLEN-1:0] value;
    } alu_res_t;

    // Reference integer ALU used for recomputation; unknown codes yield known=0, value=0.
    function automatic alu_res_t alu_eval(input logic [OPW-1:0] op,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
        alu_res_t r;
        r.known = 1'b1;
        r.value = '0;
        case (op)
            OP_ADD:  r.value = a + b;
            OP_SUB:  r.value = a - b;
            OP_AND:  r.value = a & b;
            OP_OR:   r.value = a | b;
            OP_XOR:  r.value = a ^ b;
            OP_SLL:  r.value = a << b[SHW-1:0];
            OP_SRL:  r.value = a >> b[SHW-1:0];
            OP_SLT:  r.value = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: r.known = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rc_regfile.sv
module rc_regfile
    import retire_checker_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NREG  = 32,
    localparam int AW   = $clog2(NREG),
    localparam int RDP  = 2 * LANES
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [RDP-1:0][AW-1:0]      rd_addr,
    output logic [RDP-1:0][XLEN-1:0]    rd_data,
    input  logic [LANES-1:0]            wr_en,
    input  logic [LANES-1:0][AW-1:0]    wr_addr,
    input  logic [LANES-1:0][XLEN-1:0]  wr_data
);

    logic [XLEN-1:0] regs [NREG];

    // Writes applied in slot order so the highest slot wins on a shared destination.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) regs[r] <= '0;
        end else begin
            for (int j = 0; j < LANES; j++) begin
                if (wr_en[j] && (wr_addr[j] != '0)) regs[wr_addr[j]] <= wr_data[j];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < RDP; p++) begin
            rd_data[p] = (rd_addr[p] == '0) ? '0 : regs[rd_addr[p]];
        end
    end

endmodule

// File: rtl/rc_group_eval.sv
module rc_group_eval
    import retire_checker_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 5,
    localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
)(
    input  logic [LANES-1:0]            valid,
    input  logic [LANES-1:0][OPW-1:0]   op,
    input  logic [LANES-1:0][AW-1:0]    rs1,
    input  logic [LANES-1:0][AW-1:0]    rs2,
    input  logic [LANES-1:0][AW-1:0]    rd,
    input  logic [LANES-1:0]            use_imm,
    input  logic [LANES-1:0][XLEN-1:0]  imm,
    input  logic [LANES-1:0][XLEN-1:0]  core_res,
    input  logic [LANES-1:0][XLEN-1:0]  src1_val,
    input  logic [LANES-1:0][XLEN-1:0]  src2_val,
    output logic [LANES-1:0][XLEN-1:0]  chk_val,
    output logic [LANES-1:0]            keep,
    output logic                        mismatch,
    output logic [IW-1:0]               mism_idx
);

    logic [LANES-1:0][XLEN-1:0] opa, opb;
    logic [LANES-1:0]           bad;
    alu_res_t                   res;

    // Program-order walk: operands forwarded from earlier valid writers, latest one wins.
    always_comb begin
        opa     = '0;
        opb     = '0;
        chk_val = '0;
        bad     = '0;
        res     = '0;
        for (int j = 0; j < LANES; j++) begin
            opa[j] = src1_val[j];
            opb[j] = src2_val[j];
            for (int i = 0; i < LANES; i++) begin
                if (i < j && valid[i] && rd[i] != '0) begin
                    if (rd[i] == rs1[j]) opa[j] = chk_val[i];
                    if (rd[i] == rs2[j]) opb[j] = chk_val[i];
                end
            end
            if (use_imm[j]) opb[j] = imm[j];
            res        = alu_eval(op[j], opa[j], opb[j]);
            chk_val[j] = res.value;
            bad[j]     = valid[j] && (!res.known || res.value != core_res[j]);
        end
    end

    // First faulty slot and the surviving prefix.
    always_comb begin
        mismatch = 1'b0;
        mism_idx = '0;
        keep     = '0;
        for (int j = 0; j < LANES; j++) begin
            keep[j] = valid[j] && !mismatch;
            if (bad[j] && !mismatch) begin
                mismatch = 1'b1;
                mism_idx = IW'(j);
            end
        end
    end

endmodule

// File: rtl/retire_checker.sv
module retire_checker
    import retire_checker_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NREG  = 32,
    parameter int PCW   = 32,
    localparam int AW   = $clog2(NREG)
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            retire_valid,
    input  logic [LANES-1:0][OPW-1:0]   retire_op,
    input  logic [LANES-1:0][AW-1:0]    retire_rs1,
    input  logic [LANES-1:0][AW-1:0]    retire_rs2,
    input  logic [LANES-1:0][AW-1:0]    retire_rd,
    input  logic [LANES-1:0]            retire_use_imm,
    input  logic [LANES-1:0][XLEN-1:0]  retire_imm,
    input  logic [LANES-1:0][XLEN-1:0]  retire_result,
    input  logic [LANES-1:0][PCW-1:0]   retire_pc,
    output logic                        retire_ready,
    output logic [LANES-1:0]            commit_valid,
    output logic [LANES-1:0][AW-1:0]    commit_rd,
    output logic [LANES-1:0][XLEN-1:0]  commit_data,
    output logic                        restart_req,
    output logic [PCW-1:0]              restart_pc
);

    localparam int IW  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int RDP = 2 * LANES;

    logic                        in_retry;
    logic [RDP-1:0][AW-1:0]      rf_raddr;
    logic [RDP-1:0][XLEN-1:0]    rf_rdata;
    logic [LANES-1:0][XLEN-1:0]  src1_val, src2_val, chk_val;
    logic [LANES-1:0]            keep;
    logic                        mism_any;
    logic [IW-1:0]               mism_idx;

    for (genvar g = 0; g < LANES; g++) begin : g_ports
        assign rf_raddr[2*g]   = retire_rs1[g];
        assign rf_raddr[2*g+1] = retire_rs2[g];
        assign src1_val[g]     = rf_rdata[2*g];
        assign src2_val[g]     = rf_rdata[2*g+1];
    end

    rc_regfile #(.LANES(LANES), .NREG(NREG)) u_arf (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rf_raddr),
        .rd_data (rf_rdata),
        .wr_en   (commit_valid),
        .wr_addr (commit_rd),
        .wr_data (commit_data)
    );

    rc_group_eval #(.LANES(LANES), .AW(AW)) u_eval (
        .valid    (retire_valid),
        .op       (retire_op),
        .rs1      (retire_rs1),
        .rs2      (retire_rs2),
        .rd       (retire_rd),
        .use_imm  (retire_use_imm),
        .imm      (retire_imm),
        .core_res (retire_result),
        .src1_val (src1_val),
        .src2_val (src2_val),
        .chk_val  (chk_val),
        .keep     (keep),
        .mismatch (mism_any),
        .mism_idx (mism_idx)
    );

    // First pass with a mismatch stalls; the second pass is final.
    assign retire_ready = in_retry | ~mism_any;
    assign restart_req  = in_retry & mism_any;
    assign restart_pc   = retire_pc[mism_idx] + PCW'(4);
    assign commit_rd    = retire_rd;
    assign commit_data  = chk_val;

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            commit_valid[j] = retire_ready && keep[j] && (retire_rd[j] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) in_retry <= 1'b0;
        else     in_retry <= !in_retry && mism_any;
    end

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !retire_ready |=> retire_ready);                                // R3
    AST_NO_COMMIT_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        !retire_ready |-> (commit_valid == '0));                        // R1
    AST_RESTART_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> $past(!retire_ready));                          // R4

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_COMMIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
            commit_valid[g] |-> retire_valid[g]);                       // R10
    end

endmodule

// File: tb/retire_checker_bench.sv
module retire_checker_bench;

    localparam int L = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [L-1:0]      retire_valid;
    logic [L-1:0][3:0] retire_op;
    logic [L-1:0][4:0] retire_rs1, retire_rs2, retire_rd;
    logic [L-1:0]      retire_use_imm;
    logic [L-1:0][31:0] retire_imm, retire_result, retire_pc;
    logic              retire_ready;
    logic [L-1:0]      commit_valid;
    logic [L-1:0][4:0] commit_rd;
    logic [L-1:0][31:0] commit_data;
    logic              restart_req;
    logic [31:0]       restart_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] mrf [32];
    logic [31:0] exp_val [L];
    bit          exp_ok  [L];
    logic [L-1:0] cur_corrupt;
    logic [31:0] pc_base = 32'h0000_1000;

    always #5 clk = ~clk;

    retire_checker u_retire_checker (
        .clk(clk), .rst(rst),
        .retire_valid(retire_valid), .retire_op(retire_op),
        .retire_rs1(retire_rs1), .retire_rs2(retire_rs2), .retire_rd(retire_rd),
        .retire_use_imm(retire_use_imm), .retire_imm(retire_imm),
        .retire_result(retire_result), .retire_pc(retire_pc),
        .retire_ready(retire_ready), .commit_valid(commit_valid),
        .commit_rd(commit_rd), .commit_data(commit_data),
        .restart_req(restart_req), .restart_pc(restart_pc)
    );

    function automatic logic [31:0] bm_alu(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, output bit ok);
        ok = 1;
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[4:0];
            4'd6: return a >> b[4:0];
            4'd7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin ok = 0; return 32'd0; end
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_group();
        retire_valid = '0; retire_op = '0; retire_rs1 = '0; retire_rs2 = '0;
        retire_rd = '0; retire_use_imm = '0; retire_imm = '0; retire_result = '0;
        retire_pc = '0;
    endtask

    task automatic slot(input int j, input logic [3:0] op, input int rd, input int rs1,
                        input int rs2, input bit ui, input logic [31:0] imm);
        retire_valid[j]   = 1'b1;
        retire_op[j]      = op;
        retire_rd[j]      = 5'(rd);
        retire_rs1[j]     = 5'(rs1);
        retire_rs2[j]     = 5'(rs2);
        retire_use_imm[j] = ui;
        retire_imm[j]     = imm;
        retire_pc[j]      = pc_base + 32'(4 * j);
    endtask

    // Bench model of the correct results; corrupt bits flip one bit in the core's report.
    task automatic prep(input logic [L-1:0] corrupt);
        logic [31:0] tmp [32];
        logic [31:0] a, b;
        bit ok;
        tmp = mrf;
        cur_corrupt = corrupt;
        for (int j = 0; j < L; j++) begin
            if (!retire_valid[j]) begin
                exp_val[j] = 32'd0; exp_ok[j] = 1;
                retire_result[j] = 32'hBAD0_0000 + 32'(j);
                continue;
            end
            a = (retire_rs1[j] == 0) ? 32'd0 : tmp[retire_rs1[j]];
            b = retire_use_imm[j] ? retire_imm[j] :
                ((retire_rs2[j] == 0) ? 32'd0 : tmp[retire_rs2[j]]);
            exp_val[j] = bm_alu(retire_op[j], a, b, ok);
            exp_ok[j]  = ok;
            retire_result[j] = ok ? (exp_val[j] ^ (corrupt[j] ? 32'h0000_0100 : 32'd0))
                                  : 32'h1234_5678;
            if (retire_rd[j] != 0) tmp[retire_rd[j]] = exp_val[j];
        end
    endtask

    task automatic run(input string req);
        int k = -1;
        bit ecv;
        for (int j = 0; j < L; j++)
            if (retire_valid[j] && k < 0 && (!exp_ok[j] || cur_corrupt[j])) k = j;
        #1;
        if (k >= 0) begin
            chk(retire_ready == 1'b0, "R3", {req, " ready low on first pass"}, 32'(retire_ready), 0);
            chk(commit_valid == '0, "R3", {req, " no commit during stall"}, 32'(commit_valid), 0);
            @(posedge clk); @(negedge clk); #1;
        end
        chk(retire_ready == 1'b1, "R2", {req, " group accepted"}, 32'(retire_ready), 1);
        for (int j = 0; j < L; j++) begin
            ecv = retire_valid[j] && (k < 0 || j <= k) && retire_rd[j] != 0;
            chk(commit_valid[j] == ecv, req, $sformatf("commit_valid slot %0d", j),
                32'(commit_valid[j]), 32'(ecv));
            if (ecv) begin
                chk(commit_rd[j] == retire_rd[j], "R1", $sformatf("%s commit_rd slot %0d", req, j),
                    32'(commit_rd[j]), 32'(retire_rd[j]));
                chk(commit_data[j] == exp_val[j], "R1", $sformatf("%s commit_data slot %0d", req, j),
                    commit_data[j], exp_val[j]);
            end
        end
        chk(restart_req == (k >= 0), "R4", {req, " restart_req"}, 32'(restart_req), 32'(k >= 0));
        if (k >= 0)
            chk(restart_pc == retire_pc[k] + 32'd4, "R4", {req, " restart_pc"}, restart_pc,
                retire_pc[k] + 32'd4);
        for (int j = 0; j < L; j++)
            if (retire_valid[j] && (k < 0 || j <= k) && retire_rd[j] != 0) mrf[retire_rd[j]] = exp_val[j];
        @(posedge clk); @(negedge clk);
        clear_group();
        pc_base = pc_base + 32'h40;
    endtask

    task automatic t_reset_state();
        #1;
        chk(retire_ready == 1'b1, "R11", "ready after reset", 32'(retire_ready), 1);
        chk(commit_valid == '0, "R11", "no commit after reset", 32'(commit_valid), 0);
        chk(restart_req == 1'b0, "R11", "no restart after reset", 32'(restart_req), 0);
        slot(0, 4'd0, 5, 1, 2, 0, 0);
        slot(1, 4'd3, 6, 3, 4, 0, 0);
        slot(2, 4'd7, 7, 8, 9, 0, 0);
        slot(3, 4'd4, 10, 31, 30, 0, 0);
        prep('0); run("R11 zero registers");
    endtask

    task automatic t_constants();
        slot(0, 4'd0, 1, 0, 9, 1, 32'd5);
        slot(1, 4'd0, 2, 0, 9, 1, 32'hFFFF_FFF0);
        slot(2, 4'd0, 3, 0, 9, 1, 32'd3);
        slot(3, 4'd0, 4, 0, 9, 1, 32'h8000_0001);
        prep('0); run("R7 immediates R2");
    endtask

    task automatic t_ops();
        slot(0, 4'd1, 5, 1, 2, 0, 0);
        slot(1, 4'd2, 6, 2, 4, 0, 0);
        slot(2, 4'd3, 7, 1, 3, 0, 0);
        slot(3, 4'd4, 8, 2, 4, 0, 0);
        prep('0); run("R6 sub/and/or/xor");
        slot(0, 4'd5, 9, 1, 3, 0, 0);
        slot(1, 4'd6, 10, 2, 3, 0, 0);
        slot(2, 4'd7, 11, 2, 1, 0, 0);
        slot(3, 4'd7, 12, 1, 2, 0, 0);
        prep('0); run("R6 shifts/slt");
        slot(0, 4'd5, 13, 1, 0, 1, 32'd33);
        slot(1, 4'd6, 14, 4, 0, 1, 32'd31);
        slot(2, 4'd7, 15, 4, 3, 0, 0);
        slot(3, 4'd1, 16, 0, 1, 0, 0);
        prep('0); run("R6 shift mask/signed");
    endtask

    task automatic t_forward();
        slot(0, 4'd0, 20, 0, 0, 1, 32'd7);
        slot(1, 4'd0, 21, 20, 20, 0, 0);
        slot(2, 4'd5, 20, 21, 0, 1, 32'd2);
        slot(3, 4'd4, 22, 20, 21, 0, 0);
        prep('0); run("R5 forwarding chain");
        slot(0, 4'd0, 23, 20, 0, 1, 32'd0);
        slot(1, 4'd0, 24, 22, 21, 0, 0);
        prep('0); run("R5 later writer kept");
    endtask

    task automatic t_mismatch();
        slot(0, 4'd0, 17, 1, 3, 0, 0);
        slot(1, 4'd0, 24, 1, 3, 0, 0);
        slot(2, 4'd0, 1, 0, 0, 1, 32'd99);
        slot(3, 4'd0, 25, 0, 0, 1, 32'd77);
        prep(4'b0010); run("R4 mismatch slot1");
        slot(0, 4'd0, 26, 1, 24, 0, 0);
        slot(1, 4'd0, 27, 25, 0, 1, 32'd0);
        prep('0); run("R4 dropped slots left no state");
        slot(0, 4'd3, 18, 1, 2, 0, 0);
        slot(1, 4'd0, 19, 18, 0, 1, 32'd1);
        prep(4'b0001); run("R4 mismatch slot0");
        slot(0, 4'd0, 28, 1, 1, 0, 0);
        slot(3, 4'd1, 29, 28, 3, 0, 0);
        prep(4'b1000); run("R4 mismatch slot3");
        slot(0, 4'd2, 30, 1, 2, 0, 0);
        slot(1, 4'd0, 30, 30, 0, 1, 32'd4);
        slot(2, 4'd0, 29, 0, 0, 1, 32'd11);
        slot(3, 4'd0, 28, 0, 0, 1, 32'd12);
        prep(4'b1100); run("R4 lowest faulty slot wins");
    endtask

    task automatic t_r0();
        slot(0, 4'd0, 0, 1, 3, 0, 0);
        slot(1, 4'd0, 27, 0, 1, 0, 0);
        slot(2, 4'd3, 26, 0, 0, 1, 32'd0);
        prep('0); run("R9 register zero");
    endtask

    task automatic t_invalid();
        slot(0, 4'd0, 29, 1, 0, 1, 32'd1);
        slot(1, 4'd15, 3, 1, 1, 0, 0);
        slot(2, 4'd0, 30, 3, 0, 0, 0);
        slot(3, 4'd9, 5, 0, 0, 0, 0);
        retire_valid[1] = 1'b0;
        retire_valid[3] = 1'b0;
        prep('0); run("R10 invalid slots ignored");
        slot(0, 4'd12, 3, 0, 0, 0, 0);
        slot(1, 4'd0, 5, 0, 0, 1, 32'd1);
        retire_valid = '0;
        prep('0); run("R10 all invalid");
        slot(0, 4'd0, 31, 3, 5, 0, 0);
        prep('0); run("R10 state untouched");
    endtask

    task automatic t_unknown();
        slot(0, 4'd0, 31, 1, 0, 1, 32'd2);
        slot(1, 4'd11, 31, 1, 2, 0, 0);
        slot(2, 4'd0, 6, 0, 0, 1, 32'd5);
        prep('0); run("R8 unknown opcode");
        slot(0, 4'd0, 11, 31, 0, 1, 32'd0);
        prep('0); run("R8 zero value committed");
    endtask

    initial begin
        for (int r = 0; r < 32; r++) mrf[r] = 32'd0;
        cur_corrupt = '0;
        rst = 1'b1;
        clear_group();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_constants();
        t_ops();
        t_forward();
        t_mismatch();
        t_r0();
        t_invalid();
        t_unknown();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule